// File: doc/BRIEF.md
# Nine-bit receive address matcher

This block sits between the character output of a UART receiver and the write port of its receive FIFO, where it inspects each 9-bit character at the moment the character is stored. In multi-drop links the ninth bit marks an address. The block can flag any character with that bit set. It can also compare each character against four programmable 9-bit special characters. It raises two interrupt requests. The high-priority receive request covers address and error characters. The low-priority match request covers special-character hits. Both are decided on the FIFO write strobe, not at the end of the serial frame.

A small register port holds the settings. These are a mode register, an enable register and four low-byte registers for the special characters. The ninth bit of each special character lives in the mode register. Pending requests, the per-character hit flags and two status bits are sticky. They clear when the host takes a character out of the FIFO. The interrupt identification output names the highest pending level.

Top module: `nbm_rx_addr_match`

## Requirements
- R1: After reset every register reads 0, both interrupt requests, all hit flags and both status bits are 0, and `irq_id` is 0.
- R2: Register map at `cfg_addr`:
  - Address 0 is the mode register. Bit 0 enables 9-bit mode. Bit 1 enables the address interrupt. Bits 2..5 are the ninth bits of special characters 1..4. Bits 7:6 always read 0.
  - Address 1 is the enable register. Bit 0 enables the error interrupt. Bit 1 enables matching. Bit 2 is enhanced mode. Bits 7:3 read 0.
  - Addresses 2..5 hold the low bytes of special characters 1..4.
  - Addresses 6 and 7 read 0.
  - A write takes effect at the clock edge on which `cfg_wr` is high.
- R3: With mode bits 0 and 1 both set, a character written with bit 8 set makes `irq_rx_hi` high from the clock edge that samples `rx_wr`. A character with bit 8 clear raises nothing by itself.
- R4: With mode bit 0 clear, bit 8 of a character has no effect: no address interrupt and no match are raised.
- R5: With enable bit 0 set, a character written with a parity, framing or break flag raises `irq_rx_hi`, whatever the mode. With enable bit 0 clear it does not. A pending request stays pending across later writes.
- R6: When matching is active, `match_hits[i]` sets if the full 9 bits equal special character i+1, and `irq_match` is the OR of the hit flags. A character whose low byte matches but whose ninth bit differs gives no hit.
- R7: Matching is active only when mode bit 0, enable bit 1 and enable bit 2 are all set. Otherwise no hit is recorded.
- R8: `lsr_fifo_err` sets when a written character carries a parity, framing or break flag. `lsr_overrun` sets when `rx_overrun` is high on a write. A clean address character leaves both bits at 0.
- R9: `irq_id` is 1 when `irq_rx_hi` is pending, otherwise 5 when `irq_match` is pending, otherwise 0.
- R10: A `host_rd` clears every pending request, hit flag and status bit at the next edge. When `rx_wr` falls in the same cycle, the new character's results are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| rx_wr | input | 1 | Character is being written into the receive FIFO |
| rx_char | input | 9 | Received character, bit 8 is the address marker |
| rx_parity_err | input | 1 | Parity error flag of the character |
| rx_frame_err | input | 1 | Framing error flag of the character |
| rx_break | input | 1 | Break flag of the character |
| rx_overrun | input | 1 | Overrun flag presented with the write |
| host_rd | input | 1 | Host reads a character out of the FIFO |
| irq_rx_hi | output | 1 | Level 1 request: address or error character |
| irq_match | output | 1 | Level 5 request: special character matched |
| irq_id | output | 3 | Highest pending level: 0, 1 or 5 |
| match_hits | output | 4 | Sticky per-special-character hit flags |
| lsr_fifo_err | output | 1 | Error status bit |
| lsr_overrun | output | 1 | Overrun status bit |

## Verification
Two events can land on one clock edge: a FIFO write that sets requests, and a host read that clears them. The bench provokes this both ways. In one case a clean character is written while an error request is pending. In the other an error character is written while nothing is pending. It expects the new character's outcome to survive. A behavioural model applies the same rule to every cycle of a long random phase. Register writes and host reads are scattered through that phase, and every output is compared on each falling edge.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
   typedef enum logic [2:0] {
      IRQ_NONE      = 3'd0,
      IRQ_LVL_HI    = 3'd1,
      IRQ_LVL_MATCH = 3'd5
   } irq_id_e;

   localparam int unsigned REG_MODE     = 0;
   localparam int unsigned REG_ENABLE   = 1;
   localparam int unsigned REG_SPC_BASE = 2;
   localparam int unsigned EN_W         = 3;

   typedef struct packed {
      logic enh;
      logic match_en;
      logic err_en;
   } en_t;
endpackage

// File: rtl/nbm_cfg_regs.sv
module nbm_cfg_regs
   import nbm_pkg::*;
#(
   parameter int unsigned NUM_SPC = 4,
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned ADDR_W  = 3,
   localparam int unsigned MODE_W = 2 + NUM_SPC
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_wr,
   input  logic [ADDR_W-1:0]              cfg_addr,
   input  logic [REG_W-1:0]               cfg_wdata,
   output logic [REG_W-1:0]               cfg_rdata,
   output logic [MODE_W-1:0]              mode_o,
   output en_t                            en_o,
   output logic [NUM_SPC-1:0][LOW_W:0]    spc_o
);
   if (MODE_W > REG_W) begin : g_bad_mode
      $error("mode register wider than register port");
   end
   if (LOW_W > REG_W) begin : g_bad_low
      $error("special character low part wider than register port");
   end
   if ((REG_SPC_BASE + NUM_SPC) > (1 << ADDR_W)) begin : g_bad_addr
      $error("address space too small for register map");
   end

   logic [MODE_W-1:0] mode_q;
   logic [EN_W-1:0]   en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         en_q   <= '0;
      end else if (cfg_wr) begin
         if (cfg_addr == ADDR_W'(REG_MODE))   mode_q <= cfg_wdata[MODE_W-1:0];
         if (cfg_addr == ADDR_W'(REG_ENABLE)) en_q   <= cfg_wdata[EN_W-1:0];
      end
   end

   logic [NUM_SPC-1:0][LOW_W-1:0] spc_q;

   for (genvar i = 0; i < NUM_SPC; i++) begin : g_spc
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            spc_q[i] <= '0;
         end else if (cfg_wr && cfg_addr == ADDR_W'(REG_SPC_BASE + i)) begin
            spc_q[i] <= cfg_wdata[LOW_W-1:0];
         end
      end
      assign spc_o[i] = {mode_q[2+i], spc_q[i]};
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == ADDR_W'(REG_MODE))   cfg_rdata[MODE_W-1:0] = mode_q;
      if (cfg_addr == ADDR_W'(REG_ENABLE)) cfg_rdata[EN_W-1:0]   = en_q;
      for (int i = 0; i < NUM_SPC; i++) begin
         if (cfg_addr == ADDR_W'(REG_SPC_BASE + i)) cfg_rdata[LOW_W-1:0] = spc_q[i];
      end
   end

   assign mode_o = mode_q;
   assign en_o   = en_t'(en_q);

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == ADDR_W'(REG_MODE)) |=> $stable(mode_q)); // R2
endmodule

// File: rtl/nbm_match_unit.sv
module nbm_match_unit #(
   parameter int unsigned NUM_SPC = 4,
   parameter int unsigned LOW_W   = 8
) (
   input  logic                        active,
   input  logic [LOW_W:0]              rx_char,
   input  logic [NUM_SPC-1:0][LOW_W:0] spc,
   output logic [NUM_SPC-1:0]          hits
);
   for (genvar i = 0; i < NUM_SPC; i++) begin : g_cmp
      assign hits[i] = active && (rx_char == spc[i]);
   end
endmodule

// File: rtl/nbm_irq_ctrl.sv
module nbm_irq_ctrl
   import nbm_pkg::*;
#(
   parameter int unsigned NUM_SPC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_wr,
   input  logic               host_rd,
   input  logic               addr_hit,
   input  logic               err_hit,
   input  logic               err_flags,
   input  logic               ovr_flag,
   input  logic [NUM_SPC-1:0] hits_in,
   output logic               hi_q,
   output logic [NUM_SPC-1:0] hits_q,
   output logic               ferr_q,
   output logic               ovr_q,
   output irq_id_e            irq_id
);
   logic keep;
   assign keep = !host_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= 1'b0;
         hits_q <= '0;
         ferr_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         hi_q   <= (hi_q && keep) || (rx_wr && (addr_hit || err_hit));
         hits_q <= (hits_q & {NUM_SPC{keep}}) | (rx_wr ? hits_in : '0);
         ferr_q <= (ferr_q && keep) || (rx_wr && err_flags);
         ovr_q  <= (ovr_q && keep) || (rx_wr && ovr_flag);
      end
   end

   always_comb begin
      if (hi_q)         irq_id = IRQ_LVL_HI;
      else if (|hits_q) irq_id = IRQ_LVL_MATCH;
      else              irq_id = IRQ_NONE;
   end

   AST_HI_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_q) |-> $past(rx_wr)); // R3
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !rx_wr) |=> (!hi_q && hits_q == '0 && !ferr_q && !ovr_q)); // R10
   AST_OVR_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rx_wr && ovr_flag)); // R8
endmodule

// File: rtl/nbm_rx_addr_match.sv
module nbm_rx_addr_match
   import nbm_pkg::*;
#(
   parameter int unsigned NUM_SPC = 4,
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic               rx_wr,
   input  logic [LOW_W:0]     rx_char,
   input  logic               rx_parity_err,
   input  logic               rx_frame_err,
   input  logic               rx_break,
   input  logic               rx_overrun,
   input  logic               host_rd,
   output logic               irq_rx_hi,
   output logic               irq_match,
   output logic [2:0]         irq_id,
   output logic [NUM_SPC-1:0] match_hits,
   output logic               lsr_fifo_err,
   output logic               lsr_overrun
);
   localparam int unsigned MODE_W = 2 + NUM_SPC;

   logic [MODE_W-1:0]           mode;
   en_t                         en;
   logic [NUM_SPC-1:0][LOW_W:0] spc;
   logic [NUM_SPC-1:0]          hits_now;
   logic                        nine_on, addr_hit, err_flags, err_hit, match_on;
   irq_id_e                     id_e;

   nbm_cfg_regs #(.NUM_SPC(NUM_SPC), .LOW_W(LOW_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mode_o(mode), .en_o(en), .spc_o(spc)
   );

   assign nine_on   = mode[0];
   assign addr_hit  = nine_on && mode[1] && rx_char[LOW_W];
   assign err_flags = rx_parity_err || rx_frame_err || rx_break;
   assign err_hit   = en.err_en && err_flags;
   assign match_on  = nine_on && en.enh && en.match_en;

   nbm_match_unit #(.NUM_SPC(NUM_SPC), .LOW_W(LOW_W)) u_match (
      .active(match_on), .rx_char(rx_char), .spc(spc), .hits(hits_now)
   );

   nbm_irq_ctrl #(.NUM_SPC(NUM_SPC)) u_irq (
      .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .host_rd(host_rd),
      .addr_hit(addr_hit), .err_hit(err_hit), .err_flags(err_flags),
      .ovr_flag(rx_overrun), .hits_in(hits_now),
      .hi_q(irq_rx_hi), .hits_q(match_hits), .ferr_q(lsr_fifo_err),
      .ovr_q(lsr_overrun), .irq_id(id_e)
   );

   assign irq_match = |match_hits;
   assign irq_id    = id_e;

   AST_MATCH_NEEDS_NINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_match) |-> $past(rx_wr && nine_on)); // R7
endmodule

// File: tb/nbm_rx_addr_match_bench.sv
module nbm_rx_addr_match_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       rx_wr = 1'b0;
   logic [8:0] rx_char = '0;
   logic       rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0, rx_overrun = 1'b0;
   logic       host_rd = 1'b0;
   logic       irq_rx_hi, irq_match, lsr_fifo_err, lsr_overrun;
   logic [2:0] irq_id;
   logic [3:0] match_hits;

   nbm_rx_addr_match u_nbm_rx_addr_match (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_wr(rx_wr),
      .rx_char(rx_char), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
      .rx_break(rx_break), .rx_overrun(rx_overrun), .host_rd(host_rd),
      .irq_rx_hi(irq_rx_hi), .irq_match(irq_match), .irq_id(irq_id),
      .match_hits(match_hits), .lsr_fifo_err(lsr_fifo_err), .lsr_overrun(lsr_overrun)
   );

   int checks = 0;
   int errors = 0;

   // behavioural reference model
   bit [5:0] m_mode;
   bit [2:0] m_en;
   bit [7:0] m_spc [4];
   bit       m_hi, m_ferr, m_ovr;
   bit [3:0] m_hits;

   always @(posedge clk) begin : model
      bit [3:0] nh;
      bit       anyerr;
      if (!rst_n) begin
         m_mode = 0; m_en = 0; m_hi = 0; m_ferr = 0; m_ovr = 0; m_hits = 0;
         for (int i = 0; i < 4; i++) m_spc[i] = 0;
      end else begin
         nh = 0;
         anyerr = rx_parity_err | rx_frame_err | rx_break;
         if (host_rd) begin
            m_hi = 0; m_hits = 0; m_ferr = 0; m_ovr = 0;
         end
         if (rx_wr) begin
            if (m_mode[0] && m_mode[1] && rx_char[8]) m_hi = 1;
            if (m_en[0] && anyerr) m_hi = 1;
            if (anyerr) m_ferr = 1;
            if (rx_overrun) m_ovr = 1;
            if (m_mode[0] && m_en[1] && m_en[2])
               for (int i = 0; i < 4; i++)
                  if (rx_char == {m_mode[2+i], m_spc[i]}) nh[i] = 1;
            m_hits = m_hits | nh;
         end
         if (cfg_wr) begin
            if (cfg_addr == 0) m_mode = cfg_wdata[5:0];
            if (cfg_addr == 1) m_en = cfg_wdata[2:0];
            if (cfg_addr >= 2 && cfg_addr <= 5) m_spc[cfg_addr-2] = cfg_wdata;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_rdata();
      if (cfg_addr == 0) return {2'b00, m_mode};
      if (cfg_addr == 1) return {5'b0, m_en};
      if (cfg_addr >= 2 && cfg_addr <= 5) return m_spc[cfg_addr-2];
      return 0;
   endfunction

   task automatic compare_all();
      chk("R3 R5 irq_rx_hi", irq_rx_hi, m_hi);
      chk("R6 match_hits", match_hits, m_hits);
      chk("R6 irq_match", irq_match, |m_hits);
      chk("R8 lsr_fifo_err", lsr_fifo_err, m_ferr);
      chk("R8 lsr_overrun", lsr_overrun, m_ovr);
      chk("R9 irq_id", irq_id, m_hi ? 1 : (|m_hits ? 5 : 0));
      chk("R2 cfg_rdata", cfg_rdata, exp_rdata());
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) compare_all();
      cfg_wr = 0; rx_wr = 0; host_rd = 0;
      rx_parity_err = 0; rx_frame_err = 0; rx_break = 0; rx_overrun = 0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      tick(); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
      tick();
   endtask

   task automatic peek(input logic [2:0] a);
      tick(); cfg_addr = a;
      tick();
   endtask

   task automatic put(input logic [8:0] ch, input logic [3:0] fl, input logic rd);
      tick(); rx_wr = 1; rx_char = ch; host_rd = rd;
      {rx_overrun, rx_break, rx_frame_err, rx_parity_err} = fl;
      tick();
   endtask

   task automatic rd();
      tick(); host_rd = 1;
      tick();
   endtask

   bit done = 0;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 irq_id", irq_id, 0);
      chk("R1 irq_rx_hi", irq_rx_hi, 0);
      chk("R1 match_hits", match_hits, 0);
      chk("R1 lsr bits", {lsr_fifo_err, lsr_overrun}, 0);
      peek(0); chk("R1 mode reg", cfg_rdata, 0);
      // R2 reserved bits
      wr_reg(0, 8'hFF); peek(0); chk("R2 mode readback", cfg_rdata, 8'h3F);
      wr_reg(1, 8'hFF); peek(1); chk("R2 enable readback", cfg_rdata, 8'h07);
      wr_reg(2, 8'h55); peek(2); chk("R2 spc1 readback", cfg_rdata, 8'h55);
      peek(6); chk("R2 unused addr", cfg_rdata, 0);
      // R4 9-bit mode off
      wr_reg(0, 8'h3E);
      put(9'h155, 4'b0000, 0);
      chk("R4 no addr irq", irq_rx_hi, 0);
      chk("R4 no match", irq_match, 0);
      rd();
      // R3 address interrupt, R8 clean status
      wr_reg(0, 8'h07);
      put(9'h1AA, 4'b0000, 0);
      chk("R3 addr irq", irq_rx_hi, 1);
      chk("R8 addr only status", {lsr_fifo_err, lsr_overrun}, 0);
      chk("R9 id level1", irq_id, 1);
      rd();
      chk("R10 cleared", irq_rx_hi, 0);
      put(9'h0AA, 4'b0000, 0);
      chk("R3 data char no irq", irq_rx_hi, 0);
      // R6 / R9 both pending
      put(9'h155, 4'b0000, 0);
      chk("R6 hit char1", match_hits, 4'b0001);
      chk("R9 both pending id", irq_id, 1);
      rd();
      wr_reg(0, 8'h01); wr_reg(3, 8'h66);
      put(9'h066, 4'b0000, 0);
      chk("R6 hit char2", match_hits, 4'b0010);
      chk("R9 id level5", irq_id, 5);
      rd();
      put(9'h166, 4'b0000, 0);
      chk("R6 ninth bit differs", match_hits, 0);
      // R7 gating
      wr_reg(1, 8'h03);
      put(9'h066, 4'b0000, 0);
      chk("R7 enhanced off", irq_match, 0);
      wr_reg(1, 8'h05);
      put(9'h066, 4'b0000, 0);
      chk("R7 match enable off", irq_match, 0);
      // R5 error interrupt
      wr_reg(1, 8'h07); wr_reg(0, 8'h00);
      put(9'h012, 4'b0001, 0);
      chk("R5 parity irq", irq_rx_hi, 1);
      chk("R8 fifo err", lsr_fifo_err, 1);
      put(9'h013, 4'b0000, 0);
      chk("R5 stays pending", irq_rx_hi, 1);
      rd();
      wr_reg(1, 8'h06);
      put(9'h012, 4'b0010, 0);
      chk("R5 err irq disabled", irq_rx_hi, 0);
      chk("R8 frame status", lsr_fifo_err, 1);
      rd();
      put(9'h012, 4'b1000, 0);
      chk("R8 overrun", lsr_overrun, 1);
      chk("R8 overrun no irq", irq_rx_hi, 0);
      rd();
      // R10 same-cycle write and read
      wr_reg(1, 8'h07);
      put(9'h020, 4'b0100, 0);
      put(9'h021, 4'b0000, 1);
      chk("R10 read with clean write", {irq_rx_hi, lsr_fifo_err}, 0);
      put(9'h022, 4'b0100, 1);
      chk("R10 write wins", {irq_rx_hi, lsr_fifo_err}, 2'b11);
      rd();
      // random phase
      for (int n = 0; n < 3000; n++) begin
         tick();
         if ($urandom_range(0, 9) == 0) begin
            cfg_wr = 1; cfg_addr = 3'($urandom_range(0, 7)); cfg_wdata = 8'($urandom);
         end else begin
            cfg_addr = 3'($urandom_range(0, 7));
         end
         rx_wr = ($urandom_range(0, 2) != 0);
         rx_char = ($urandom_range(0, 1) != 0) ? {1'($urandom), m_spc[$urandom_range(0, 3)]} : 9'($urandom);
         host_rd = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 5) == 0) {rx_overrun, rx_break, rx_frame_err, rx_parity_err} = 4'($urandom);
      end
      tick();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule